// File: doc/BRIEF.md
# Double-Indexed DMA Address Generator

This block produces the source address sequence of a two-dimensional DMA transfer. A transfer is a block made of frames, and each frame is made of elements. A load strobe captures the whole configuration and resets the element and frame counters. The configuration is a 32-bit start address supplied as two 16-bit halves, an element size code, an addressing mode, 16-bit element and frame counts, a signed 16-bit element index and a signed 32-bit frame index. After the load, each advance strobe makes the block present one address, tagged with end-of-frame and end-of-block flags.

Three addressing behaviours are offered. In the constant mode every address equals the start. In the post-increment mode the address moves forward by one element size per element. In the double-indexed mode the step between elements and the step between frames are set separately and may be negative. This lets a consumer walk an image column by column, which rotates it by 90 degrees while it is read. Burst access is not allowed while double-indexed addressing is loaded, and a dedicated output tells the data mover so. Once the final element has been issued, the block gives a one-cycle done pulse and then ignores advance strobes until the next load.

Top module: `dix_addr_gen`

## Requirements
- R1: On a load strobe the block captures every configuration input and sets the current address to {start_hi, start_lo}. It clears both counters and raises busy on the following cycle, with addr_valid low in that cycle.
- R2: The size code sets the element size: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes.
- R3: With mode code 0 every issued address equals the start address.
- R4: With mode code 1 or 2 each issued address is the previous one plus the element size, frame boundaries included.
- R5: With mode code 3 the address between two elements of the same frame advances by element size + element index - 1. The element index is a signed 16-bit value.
- R6: With mode code 3 the address from the last element of a frame to the first element of the next advances by element size + frame index - 1. The frame index is a signed 32-bit value, and the sum wraps modulo 2^32.
- R7: An advance strobe while busy gives, one cycle later, addr_valid high with the current address. frame_end is high exactly on the last element of each frame. A count of 0 acts as a count of 1.
- R8: block_end is high exactly on the last element of the last frame, and always together with frame_end.
- R9: done is a one-cycle pulse in the cycle after the output carrying block_end. From then on, busy is low and advance strobes give no addr_valid until the next load.
- R10: burst_ok is low while the loaded mode code is 3 and high otherwise.
- R11: After reset, busy, addr_valid, frame_end, block_end and done are low, and burst_ok is high.
- R12: A load in the middle of a block abandons it, and the following advances restart from the new start address with cleared counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture configuration, reset counters |
| start_hi | input | 16 | Upper half of start address |
| start_lo | input | 16 | Lower half of start address |
| size_code | input | 2 | Element size code |
| mode | input | 2 | Addressing mode code |
| elem_count | input | 16 | Elements per frame |
| frame_count | input | 16 | Frames per block |
| elem_index | input | 16 | Signed element index |
| frame_index | input | 32 | Signed frame index |
| advance | input | 1 | Request next address |
| addr | output | 32 | Issued address |
| addr_valid | output | 1 | addr holds a new address this cycle |
| frame_end | output | 1 | Issued address is last of its frame |
| block_end | output | 1 | Issued address is last of the block |
| done | output | 1 | One-cycle pulse after the block ends |
| busy | output | 1 | Block loaded and not finished |
| burst_ok | output | 1 | Burst access permitted |

## Verification
The bench builds the block with its default widths: a 32-bit address, 16-bit counts, a 16-bit element index and a 32-bit frame index. With these it can use negative frame indices of full width and start addresses near zero. That makes it possible to check address wrap-around and a complete 90-degree rotation walk of a small 2-byte-pixel image. Small counts keep every element of each block observable, and zero counts exercise the single-element block.

// File: rtl/dix_addr_gen.sv
module dix_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int EW = 16,
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW/2-1:0] start_hi,
  input  logic [AW/2-1:0] start_lo,
  input  logic [1:0]    size_code,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] elem_count,
  input  logic [CW-1:0] frame_count,
  input  logic [EW-1:0] elem_index,
  input  logic [FW-1:0] frame_index,
  input  logic          advance,
  output logic [AW-1:0] addr,
  output logic          addr_valid,
  output logic          frame_end,
  output logic          block_end,
  output logic          done,
  output logic          busy,
  output logic          burst_ok
);
  logic [AW-1:0] cur;
  logic [CW-1:0] ecnt, fcnt, elim, flim;
  logic [1:0]    size_r, mode_r;
  logic [EW-1:0] eidx_r;
  logic [FW-1:0] fidx_r;
  logic [AW-1:0] esz, step_amt;
  logic          last_e, last_f;

  always_comb begin
    case (size_r)
      2'd0:    esz = AW'(1);
      2'd1:    esz = AW'(2);
      default: esz = AW'(4);
    endcase
  end

  assign last_e = ({1'b0, ecnt} + 1'b1) >= {1'b0, elim};
  assign last_f = ({1'b0, fcnt} + 1'b1) >= {1'b0, flim};

  always_comb begin
    if (mode_r == 2'd0)
      step_amt = '0;
    else if (mode_r == 2'd3)
      step_amt = esz - AW'(1) + (last_e ? AW'($signed(fidx_r)) : AW'($signed(eidx_r)));
    else
      step_amt = esz;
  end

  assign burst_ok = (mode_r != 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0; ecnt <= '0; fcnt <= '0; elim <= '0; flim <= '0;
      size_r <= '0; mode_r <= '0; eidx_r <= '0; fidx_r <= '0;
      addr <= '0; addr_valid <= 1'b0; frame_end <= 1'b0;
      block_end <= 1'b0; done <= 1'b0; busy <= 1'b0;
    end else begin
      addr_valid <= 1'b0;
      frame_end  <= 1'b0;
      block_end  <= 1'b0;
      done       <= addr_valid && block_end;
      if (load) begin
        cur    <= {start_hi, start_lo};
        ecnt   <= '0;
        fcnt   <= '0;
        elim   <= elem_count;
        flim   <= frame_count;
        size_r <= size_code;
        mode_r <= mode;
        eidx_r <= elem_index;
        fidx_r <= frame_index;
        busy   <= 1'b1;
      end else if (advance && busy) begin
        addr       <= cur;
        addr_valid <= 1'b1;
        frame_end  <= last_e;
        block_end  <= last_e && last_f;
        cur        <= cur + step_amt;
        if (last_e) begin
          ecnt <= '0;
          if (last_f) busy <= 1'b0;
          else        fcnt <= fcnt + 1'b1;
        end else begin
          ecnt <= ecnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dix_addr_gen_chk.sv
module dix_addr_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load,
  input logic [1:0] mode,
  input logic       addr_valid,
  input logic       frame_end,
  input logic       block_end,
  input logic       done,
  input logic       busy,
  input logic       burst_ok
);
  // R1
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy && !addr_valid);
  // R8
  blk_with_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_end |-> frame_end && addr_valid);
  // R9
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(addr_valid && block_end));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> !addr_valid);
  // R10
  no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode == 2'd3) |=> !burst_ok);
endmodule

bind dix_addr_gen dix_addr_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .mode(mode),
  .addr_valid(addr_valid), .frame_end(frame_end), .block_end(block_end),
  .done(done), .busy(busy), .burst_ok(burst_ok)
);

// File: tb/sim_dix_addr_gen.sv
module sim_dix_addr_gen;
  logic clk = 0, rst_n = 0, load = 0, advance = 0;
  logic [15:0] start_hi = 0, start_lo = 0, elem_count = 0, frame_count = 0, elem_index = 0;
  logic [1:0]  size_code = 0, mode = 0;
  logic [31:0] frame_index = 0;
  logic [31:0] addr;
  logic addr_valid, frame_end, block_end, done, busy, burst_ok;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  dix_addr_gen u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [31:0] st, input int sc, input int md, input int e, input int f,
                         input int ei, input int fi);
    @(negedge clk);
    {start_hi, start_lo} = st; size_code = 2'(sc); mode = 2'(md);
    elem_count = 16'(e); frame_count = 16'(f); elem_index = 16'(ei); frame_index = 32'(fi);
    load = 1;
    @(posedge clk); #1 load = 0;
    chk(busy && !addr_valid, "R1 busy after load", {30'd0, busy, addr_valid}, 32'd2);
    chk(burst_ok == (md != 3), "R10 burst_ok", {31'd0, burst_ok}, {31'd0, md != 3});
  endtask

  task automatic do_adv(output logic [31:0] a, output logic v, output logic fe, output logic be);
    @(negedge clk); advance = 1;
    @(posedge clk); #1 advance = 0;
    a = addr; v = addr_valid; fe = frame_end; be = block_end;
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] st, input int es, input int md,
      input int e_n, input int f, input int e, input longint ei, input longint fi);
    longint se, sf;
    se = es + ei - 1; sf = es + fi - 1;
    if (md == 0) return st;
    if (md == 3) return st + 32'(longint'(f) * ((e_n - 1) * se + sf) + longint'(e) * se);
    return st + 32'((longint'(f) * e_n + e) * es);
  endfunction

  task automatic run_block(input string req, input logic [31:0] st, input int sc, input int md,
                           input int e, input int f, input int ei, input int fi);
    int es, en, fn;
    logic [31:0] a; logic v, fe, be;
    es = (sc == 0) ? 1 : (sc == 1) ? 2 : 4;
    en = (e == 0) ? 1 : e; fn = (f == 0) ? 1 : f;
    do_load(st, sc, md, e, f, ei, fi);
    for (int fi_n = 0; fi_n < fn; fi_n++)
      for (int ej = 0; ej < en; ej++) begin
        logic [31:0] x;
        x = exp_addr(st, es, md, en, fi_n, ej, longint'(ei), longint'(fi));
        do_adv(a, v, fe, be);
        chk(v && a == x, {req, " addr"}, a, x);
        chk(fe == (ej == en - 1), "R7 frame_end", {31'd0, fe}, {31'd0, ej == en - 1});
        chk(be == (ej == en - 1 && fi_n == fn - 1), "R8 block_end", {31'd0, be},
            {31'd0, ej == en - 1 && fi_n == fn - 1});
      end
    do_adv(a, v, fe, be);
    chk(done && !v, "R9 done pulse, advance ignored", {30'd0, done, v}, 32'd2);
    @(posedge clk); #1;
    chk(!done && !busy, "R9 done one cycle, idle", {30'd0, done, busy}, 32'd0);
  endtask

  task automatic t_midreload;
    logic [31:0] a; logic v, fe, be;
    do_load(32'h0000_1000, 2, 1, 3, 1, 0, 0);
    do_adv(a, v, fe, be);
    do_adv(a, v, fe, be);
    do_load(32'h0000_2000, 2, 1, 3, 1, 0, 0);
    do_adv(a, v, fe, be);
    chk(v && a == 32'h2000 && !fe, "R12 restart after reload", a, 32'h2000);
    do_adv(a, v, fe, be);
    do_adv(a, v, fe, be);
    chk(a == 32'h2008 && fe && be, "R12 counters cleared", a, 32'h2008);
    @(posedge clk); #1;
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !addr_valid && !frame_end && !block_end && !done && burst_ok, "R11 reset state",
        {26'd0, busy, addr_valid, frame_end, block_end, done, burst_ok}, 32'd1);
    @(negedge clk); rst_n = 1;
    run_block("R4 R2 incr 4B", 32'h8000_0010, 2, 1, 3, 2, 0, 0);
    run_block("R4 R2 mode2 2B", 32'h0000_0100, 1, 2, 2, 2, 0, 0);
    run_block("R3 R2 const 1B", 32'h1234_5678, 0, 0, 2, 2, 0, 0);
    run_block("R5 R6 rotate", 32'h0004_0000, 1, 3, 3, 4, 7, -15);
    run_block("R5 R6 negative wrap", 32'h0000_0004, 0, 3, 2, 3, -3, -20);
    run_block("R2 size code 3", 32'h0000_0040, 3, 1, 2, 1, 0, 0);
    run_block("R7 zero counts", 32'h0000_0ABC, 2, 1, 0, 0, 0, 0);
    t_midreload();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule